// File: doc/BRIEF.md
# Atomic Test-and-Set Bus Unit

This unit carries out an indivisible read-modify-write on a single byte of shared memory. It serves one master on a bus that several masters share. A request with an address starts the sequence. The unit first raises a lock line and waits for the arbiter's grant. It then reads the addressed byte and writes the same byte back with its top bit forced high.

The lock is held from before the read until the write has been acknowledged, so the arbiter has no chance to hand the bus to another master between the two accesses. Once the write completes, the unit reports flags taken from the byte as it was before the change. The sign flag is the old top bit, the zero flag is set when the old byte was zero, and the overflow and carry flags are cleared. A one-cycle done pulse marks the end.

With these rules the byte works as a hardware semaphore. Among masters competing for a byte that starts at zero, only the first one sees the zero flag set.

Top module: `tas_unit`

## Requirements
- R1: While reset is asserted and after it is released, lock, read strobe, write strobe, done and all four flags are low.
- R2: A request seen while idle raises lock on the next cycle. No read strobe appears until the grant input has been sampled high with lock already raised.
- R3: The read strobe is only ever high together with lock, and it carries the address captured with the request.
- R4: The cycle after a read is acknowledged, the write strobe rises with no read strobe in between. The write goes to the same address, and its data equals the read byte with bit 7 set and bits 6..0 unchanged.
- R5: Lock stays high without a gap from the cycle after the request until the write acknowledge. It falls on the cycle after that acknowledge.
- R6: The cycle after the write acknowledge, done is high for exactly one cycle. At that point the sign flag equals bit 7 of the byte read, the zero flag is 1 exactly when that byte was 0x00, and the overflow and carry flags are 0.
- R7: The flags keep their values in every cycle in which done is low.
- R8: A request that arrives while a sequence is in progress is ignored, including in the cycle of the write acknowledge. No second sequence starts and its address is never touched. A request in the done cycle itself is accepted.
- R9: Two sequences on a byte that starts at 0x00 give Z=1, N=0 for the first and Z=0, N=1 for the second.
- R10: While a read or write waits for its acknowledge, the strobe, address and write data stay stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Start a test-and-set sequence |
| req_addr_i | input | AW | Byte address for the sequence |
| grant_i | input | 1 | Bus granted by the arbiter |
| lock_o | output | 1 | Bus lock request, held for the whole sequence |
| mem_rd_o | output | 1 | Read strobe |
| mem_wr_o | output | 1 | Write strobe |
| mem_addr_o | output | AW | Byte address of the access |
| mem_wdata_o | output | 8 | Write data |
| mem_rdata_i | input | 8 | Read data, valid with acknowledge |
| mem_ack_i | input | 1 | Access acknowledge |
| flag_n_o | output | 1 | Sign of the old byte |
| flag_z_o | output | 1 | Old byte was zero |
| flag_v_o | output | 1 | Overflow flag, cleared |
| flag_c_o | output | 1 | Carry flag, cleared |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
Two events can fall in the same cycle: a new request, and the acknowledge that ends the write. The memory responder in the bench raises a request in exactly the cycle it acknowledges the write. A second run raises the request one cycle later, in the done cycle. In the first case the stray address must stay untouched and only one done may appear. In the second case the request must start a full new locked sequence right away. The per-cycle reference model judges both outcomes, together with the memory contents.

// File: rtl/tas_unit.sv
module tas_unit #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic          grant_i,
  output logic          lock_o,
  output logic          mem_rd_o,
  output logic          mem_wr_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [7:0]    mem_wdata_o,
  input  logic [7:0]    mem_rdata_i,
  input  logic          mem_ack_i,
  output logic          flag_n_o,
  output logic          flag_z_o,
  output logic          flag_v_o,
  output logic          flag_c_o,
  output logic          done_o
);

  typedef enum logic [1:0] {S_IDLE, S_LOCK, S_READ, S_WRITE} st_t;

  st_t           st;
  logic [AW-1:0] addr_q;
  logic [7:0]    data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      addr_q   <= '0;
      data_q   <= '0;
      done_o   <= 1'b0;
      flag_n_o <= 1'b0;
      flag_z_o <= 1'b0;
      flag_v_o <= 1'b0;
      flag_c_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      case (st)
        S_IDLE:  if (req_i) begin
                   addr_q <= req_addr_i;
                   st     <= S_LOCK;
                 end
        S_LOCK:  if (grant_i) st <= S_READ;
        S_READ:  if (mem_ack_i) begin
                   data_q <= mem_rdata_i;
                   st     <= S_WRITE;
                 end
        S_WRITE: if (mem_ack_i) begin
                   st       <= S_IDLE;
                   done_o   <= 1'b1;
                   flag_n_o <= data_q[7];
                   flag_z_o <= (data_q == 8'h00);
                   flag_v_o <= 1'b0;
                   flag_c_o <= 1'b0;
                 end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign lock_o      = (st != S_IDLE);
  assign mem_rd_o    = (st == S_READ);
  assign mem_wr_o    = (st == S_WRITE);
  assign mem_addr_o  = addr_q;
  assign mem_wdata_o = {1'b1, data_q[6:0]};

  AST_RD_UNDER_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_o |-> lock_o); // R3
  AST_RD_TO_WR: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_o && mem_ack_i) |=> (mem_wr_o && !mem_rd_o && lock_o)); // R4
  AST_WR_SAME_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_o && mem_ack_i) |=> (mem_addr_o == $past(mem_addr_o))); // R4
  AST_UNLOCK_AFTER_WR: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_o && mem_ack_i) |=> (done_o && !lock_o)); // R5
  AST_DONE_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!flag_v_o && !flag_c_o)); // R6
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R6
  AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> $stable({flag_n_o, flag_z_o, flag_v_o, flag_c_o})); // R7
  AST_RD_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_o && !mem_ack_i) |=> (mem_rd_o && $stable(mem_addr_o))); // R10
  AST_WR_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_o && !mem_ack_i) |=> (mem_wr_o && $stable(mem_wdata_o))); // R10

endmodule

// File: tb/tas_unit_bench.sv
module tas_unit_bench;
  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req = 1'b0;
  logic [AW-1:0] raddr = '0;
  logic          grant = 1'b1;
  logic          lock, rd, wr, ack = 1'b0, fn, fz, fv, fc, done;
  logic [AW-1:0] maddr;
  logic [7:0]    wdata, rdata = 8'h00;

  always #5 clk = ~clk;

  tas_unit #(.AW(AW)) u_tas_unit (
    .clk(clk), .rst_n(rst_n), .req_i(req), .req_addr_i(raddr), .grant_i(grant),
    .lock_o(lock), .mem_rd_o(rd), .mem_wr_o(wr), .mem_addr_o(maddr),
    .mem_wdata_o(wdata), .mem_rdata_i(rdata), .mem_ack_i(ack),
    .flag_n_o(fn), .flag_z_o(fz), .flag_v_o(fv), .flag_c_o(fc), .done_o(done)
  );

  int checks = 0, bad = 0, ndone = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic summary;
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  endtask

  // memory responder
  logic [7:0] mem [256];
  int lat = 0, wcnt = 0, poke_arm = 0;
  bit poke_clr = 0;
  logic [AW-1:0] poke_addr = '0;

  always @(posedge clk) begin
    #2;
    ack = 1'b0;
    if (poke_clr) begin req = 1'b0; poke_clr = 0; end
    if (poke_arm == 2) begin req = 1'b1; raddr = poke_addr; poke_clr = 1; poke_arm = 0; end
    if (rst_n && (rd || wr)) begin
      if (wcnt >= lat) begin
        ack = 1'b1;
        wcnt = 0;
        if (rd) rdata = mem[maddr[7:0]];
        else begin
          mem[maddr[7:0]] = wdata;
          if (poke_arm == 1) begin
            req = 1'b1; raddr = poke_addr; poke_clr = 1; poke_arm = 0;
          end else if (poke_arm == 3) poke_arm = 2;
        end
      end else wcnt++;
    end else wcnt = 0;
  end

  // behavioural reference: 0 idle, 1 wait grant, 2 read, 3 write
  int ph = 0;
  logic [AW-1:0] ea = '0;
  logic [7:0] ed = '0;
  bit en = 0, ez = 0, edone = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      ph = 0; en = 0; ez = 0; edone = 0;
    end else begin
      edone = 0;
      if (ph == 0) begin
        if (req) begin ph = 1; ea = raddr; end
      end else if (ph == 1) begin
        if (grant) ph = 2;
      end else if (ph == 2) begin
        if (ack) begin ed = rdata; ph = 3; end
      end else if (ack) begin
        ph = 0; edone = 1; en = ed[7]; ez = (ed == 8'h00);
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk(lock == (ph != 0), "R5 lock", lock, ph != 0);
      chk(rd == (ph == 2), "R2 read strobe", rd, ph == 2);
      chk(!rd || lock, "R3 read without lock", lock, 1);
      chk(wr == (ph == 3), "R4 write strobe", wr, ph == 3);
      if (rd || wr) chk(maddr == ea, "R3 access address", maddr, ea);
      if (wr) chk(wdata == (ed | 8'h80), "R4 write data", wdata, ed | 8'h80);
      chk(done == edone, "R6 done", done, edone);
      chk(fn == en && fz == ez, "R7 flags N/Z", {fn, fz}, {en, ez});
      chk(!fv && !fc, "R6 flags V/C", {fv, fc}, 0);
      if (done) ndone++;
    end
  end

  task automatic wait_done(input int target);
    for (int i = 0; i < 200 && ndone < target; i++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic run_op(input logic [AW-1:0] a, input int gdelay);
    int tgt;
    tgt = ndone + 1;
    @(posedge clk); #2;
    req = 1'b1; raddr = a; grant = (gdelay == 0);
    @(posedge clk); #2;
    req = 1'b0;
    if (gdelay > 0) begin
      repeat (gdelay) @(posedge clk);
      #2 grant = 1'b1;
    end
    wait_done(tgt);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    mem[8'h22] = 8'h35;
    mem[8'h33] = 8'hC3;
    mem[8'h44] = 8'h01;
    mem[8'h55] = 8'h7F;
    mem[8'h66] = 8'h00;
    mem[8'h77] = 8'h12;
    repeat (3) @(negedge clk);
    chk(!lock && !rd && !wr && !done && !fn && !fz && !fv && !fc, "R1 in reset",
        {lock, rd, wr, done, fn, fz, fv, fc}, 0);
    @(posedge clk); #2 rst_n = 1'b1;
    @(negedge clk);
    chk(!lock && !rd && !wr && !done && !fn && !fz, "R1 after reset",
        {lock, rd, wr, done, fn, fz}, 0);

    // R9 semaphore on a cleared byte
    run_op(16'h0010, 0);
    chk(fz && !fn, "R9 first taker", {fn, fz}, 2'b01);
    chk(mem[8'h10] == 8'h80, "R4 byte set", mem[8'h10], 8'h80);
    run_op(16'h0010, 0);
    chk(!fz && fn, "R9 second taker", {fn, fz}, 2'b10);

    // R2 grant held off
    run_op(16'h0022, 5);
    chk(!fz && !fn && mem[8'h22] == 8'hB5, "R2 delayed grant", mem[8'h22], 8'hB5);

    // R10 wait states
    lat = 3;
    run_op(16'h0033, 0);
    chk(fn && !fz && mem[8'h33] == 8'hC3, "R10 slow memory", {fn, fz, mem[8'h33]}, {2'b10, 8'hC3});
    lat = 1;
    run_op(16'h0044, 2);
    chk(mem[8'h44] == 8'h81 && !fn && !fz, "R6 odd byte", mem[8'h44], 8'h81);

    // R8 request while busy (during read wait)
    lat = 4;
    begin
      int tgt;
      tgt = ndone + 1;
      @(posedge clk); #2 req = 1'b1; raddr = 16'h0055;
      @(posedge clk); #2 req = 1'b0;
      repeat (2) @(posedge clk);
      #2 req = 1'b1; raddr = 16'h0077;
      @(posedge clk); #2 req = 1'b0;
      wait_done(tgt);
      repeat (10) @(negedge clk);
      chk(ndone == tgt, "R8 busy request ignored", ndone, tgt);
      chk(mem[8'h77] == 8'h12, "R8 stray address untouched", mem[8'h77], 8'h12);
      chk(mem[8'h55] == 8'hFF, "R4 write back", mem[8'h55], 8'hFF);
    end

    // R8 request in the write-acknowledge cycle
    lat = 0;
    poke_arm = 1; poke_addr = 16'h0077;
    begin
      int tgt;
      tgt = ndone + 1;
      run_op(16'h0066, 0);
      repeat (10) @(negedge clk);
      chk(ndone == tgt, "R8 request at write ack ignored", ndone, tgt);
      chk(mem[8'h77] == 8'h12, "R8 untouched after ack-cycle request", mem[8'h77], 8'h12);
      chk(fz && !fn, "R6 zero byte flags", {fn, fz}, 2'b01);
    end

    // R8 request in the done cycle is accepted
    poke_arm = 3; poke_addr = 16'h0077;
    begin
      int tgt;
      tgt = ndone + 2;
      run_op(16'h0066, 0);
      wait_done(tgt);
      chk(ndone == tgt, "R8 done-cycle request accepted", ndone, tgt);
      chk(mem[8'h77] == 8'h92, "R8 second sequence wrote", mem[8'h77], 8'h92);
      chk(!fn && !fz, "R7 flags of last sequence", {fn, fz}, 0);
    end

    summary();
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; bad++;
    $display("FAIL watchdog expired act=0 exp=1");
    summary();
  end
endmodule